// File: doc/BRIEF.md
# Display RAM Write Address Sequencer

This block stands between a host port and a display memory. A host loads a column pointer and a row pointer, then streams pixel bytes. The block forms the memory write for each byte: which physical column, which row, and in what bit and byte order. It then moves the pointers to the next location, so that a long run of data fills a rectangular window without further address loads.

Two controls change the stored layout. Mirror mode runs the host columns from the far end of the memory row. Bit-swap mode stores every byte with its bit order reversed. In the wide access width, one host write carries two bytes for two neighbouring columns. The pointer then moves by two, and the block returns the pair in the order that suits the physical columns it covers. Each write reaches the memory port one clock after the host strobe.

Top module: `dram_wr_order`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears both pointers to 00H and drives `mem_we`, `mem_pair`, `mem_col`, `mem_row` and `mem_data` to zero.
- R2: `mem_we` is high for exactly one cycle, in the cycle after each cycle with `wr_strobe` high, and is low in every other cycle.
- R3: With `swap_bits` at 1, each stored byte is the bit reversal of the host byte: host bit i goes to bit 7-i. With `swap_bits` at 0, the bits are stored unchanged.
- R4: In narrow access (`wide16`=0) the byte comes from `wr_data[7:0]` and leaves on `mem_data[7:0]`, with `mem_data[15:8]` at zero. `mem_col` is the column pointer when `mirror` is 0, and COL_LAST minus the pointer when `mirror` is 1. COL_LAST defaults to BFH.
- R5: In wide access (`wide16`=1) `mem_pair` is 1. `mem_data[15:8]` goes to column `mem_col` and `mem_data[7:0]` goes to `mem_col`+1. With `mirror` at 0, `mem_col` is the pointer P and `mem_data` equals the host word. With `mirror` at 1, `mem_col` is COL_LAST-P-1 and the two host bytes trade places.
- R6: In column-advance mode (`step_row`=0), a write moves the column pointer up by 1 in narrow access or by 2 in wide access. The row pointer stays as it is unless the column wraps.
- R7: In column-advance mode, when the stepped column would exceed `col_end`, the column returns to 00H and the row advances by one. A row already at `row_end` returns to 00H.
- R8: In row-advance mode (`step_row`=1), a write moves the row pointer up by 1. A row at `row_end` returns to 00H instead, and the column then steps by 1 or 2, returning to 00H if the step would exceed `col_end`.
- R9: `col_load` and `row_load` set their pointer to `load_value` at the next edge. A load overrides any pointer advance in the same cycle, and a write in that cycle uses the old pointer.
- R10: `mem_row` carries the row pointer value as it stood in the cycle of the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| col_load | input | 1 | Load column pointer from `load_value` |
| row_load | input | 1 | Load row pointer from `load_value` |
| load_value | input | 8 | Pointer load value |
| wr_strobe | input | 1 | Host pixel-data write |
| wr_data | input | 16 | Host write data (narrow uses bits 7:0) |
| wide16 | input | 1 | 1: two-byte access, 0: one-byte access |
| mirror | input | 1 | Reverse the column mapping |
| swap_bits | input | 1 | Reverse the bit order within each byte |
| step_row | input | 1 | 1: row auto-advances first, 0: column first |
| col_end | input | 8 | Last column of the write window |
| row_end | input | 8 | Last row of the write window |
| mem_we | output | 1 | Memory write enable |
| mem_pair | output | 1 | Write covers two columns |
| mem_col | output | 8 | Physical column (lowest of a pair) |
| mem_row | output | 8 | Row address |
| mem_data | output | 16 | Formatted write data |

## Verification
A pointer that takes a wrong step does not show at once. It shows one clock later, when the next write sends the wrong `mem_col` or `mem_row`. After that, every following write lands in the wrong place until the host reloads the pointer. A missed wrap shows up the same way, as a column past `col_end` or a row that stays fixed on the write after the window edge. A mistake in mirror or swap handling shows in `mem_col` or `mem_data` in the very cycle of the write it affects.

// File: rtl/dram_wo_pkg.sv
package dram_wo_pkg;

    // The two bytes of one memory write, in physical column order
    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } byte_pair_t;

    typedef enum logic {
        ADV_COL = 1'b0,
        ADV_ROW = 1'b1
    } adv_mode_e;

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            r[i] = b[7-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/dram_addr_step.sv
module dram_addr_step
    import dram_wo_pkg::*;
#(
    parameter int XW = 8,
    parameter int YW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          pair,
    input  adv_mode_e     mode,
    input  logic [XW-1:0] col_end,
    input  logic [YW-1:0] row_end,
    input  logic          col_load,
    input  logic          row_load,
    input  logic [XW-1:0] col_value,
    input  logic [YW-1:0] row_value,
    output logic [XW-1:0] ax_q,
    output logic [YW-1:0] ay_q
);
    logic [XW:0]   col_stepped;
    logic          col_over;
    logic          row_at_end;
    logic [XW-1:0] col_next;
    logic [YW-1:0] row_next;
    logic [XW-1:0] col_adv;
    logic [YW-1:0] row_adv;

    assign col_stepped = {1'b0, ax_q} + (pair ? (XW+1)'(2) : (XW+1)'(1));
    assign col_over    = col_stepped > {1'b0, col_end};
    assign row_at_end  = ay_q >= row_end;
    assign col_next    = col_over ? '0 : col_stepped[XW-1:0];
    assign row_next    = row_at_end ? '0 : ay_q + 1'b1;

    always_comb begin
        col_adv = ax_q;
        row_adv = ay_q;
        if (mode == ADV_COL) begin
            col_adv = col_next;
            if (col_over) row_adv = row_next;
        end else begin
            row_adv = row_next;
            if (row_at_end) col_adv = col_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ax_q <= '0;
            ay_q <= '0;
        end else begin
            if (adv) begin
                ax_q <= col_adv;
                ay_q <= row_adv;
            end
            if (col_load) ax_q <= col_value;
            if (row_load) ay_q <= row_value;
        end
    end
endmodule

// File: rtl/dram_wr_format.sv
module dram_wr_format
    import dram_wo_pkg::*;
#(
    parameter int          XW       = 8,
    parameter int unsigned COL_LAST = 191
) (
    input  logic [XW-1:0] ax,
    input  logic          pair,
    input  logic          mirror,
    input  logic          swap_bits,
    input  logic [15:0]   host_data,
    output logic [XW-1:0] phys_col,
    output byte_pair_t    phys_data
);
    localparam logic [XW-1:0] LAST = XW'(COL_LAST);

    logic [7:0] b_hi;
    logic [7:0] b_lo;

    assign b_hi = swap_bits ? rev8(host_data[15:8]) : host_data[15:8];
    assign b_lo = swap_bits ? rev8(host_data[7:0])  : host_data[7:0];

    always_comb begin
        if (!pair) begin
            phys_col     = mirror ? LAST - ax : ax;
            phys_data.hi = 8'h00;
            phys_data.lo = b_lo;
        end else if (!mirror) begin
            phys_col     = ax;
            phys_data.hi = b_hi;
            phys_data.lo = b_lo;
        end else begin
            phys_col     = LAST - ax - 1'b1;
            phys_data.hi = b_lo;
            phys_data.lo = b_hi;
        end
    end
endmodule

// File: rtl/dram_wr_order.sv
module dram_wr_order
    import dram_wo_pkg::*;
#(
    parameter int          XW       = 8,
    parameter int          YW       = 8,
    parameter int unsigned COL_LAST = 191
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          col_load,
    input  logic          row_load,
    input  logic [7:0]    load_value,
    input  logic          wr_strobe,
    input  logic [15:0]   wr_data,
    input  logic          wide16,
    input  logic          mirror,
    input  logic          swap_bits,
    input  logic          step_row,
    input  logic [XW-1:0] col_end,
    input  logic [YW-1:0] row_end,
    output logic          mem_we,
    output logic          mem_pair,
    output logic [XW-1:0] mem_col,
    output logic [YW-1:0] mem_row,
    output logic [15:0]   mem_data
);
    logic [XW-1:0] ax_q;
    logic [YW-1:0] ay_q;
    logic [XW-1:0] fmt_col;
    byte_pair_t    fmt_data;
    adv_mode_e     mode;

    assign mode = step_row ? ADV_ROW : ADV_COL;

    dram_addr_step #(.XW(XW), .YW(YW)) u_step (
        .clk       (clk),
        .rst       (rst),
        .adv       (wr_strobe),
        .pair      (wide16),
        .mode      (mode),
        .col_end   (col_end),
        .row_end   (row_end),
        .col_load  (col_load),
        .row_load  (row_load),
        .col_value (XW'(load_value)),
        .row_value (YW'(load_value)),
        .ax_q      (ax_q),
        .ay_q      (ay_q)
    );

    dram_wr_format #(.XW(XW), .COL_LAST(COL_LAST)) u_fmt (
        .ax        (ax_q),
        .pair      (wide16),
        .mirror    (mirror),
        .swap_bits (swap_bits),
        .host_data (wr_data),
        .phys_col  (fmt_col),
        .phys_data (fmt_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we   <= 1'b0;
            mem_pair <= 1'b0;
            mem_col  <= '0;
            mem_row  <= '0;
            mem_data <= '0;
        end else begin
            mem_we <= wr_strobe;
            if (wr_strobe) begin
                mem_pair <= wide16;
                mem_col  <= fmt_col;
                mem_row  <= ay_q;
                mem_data <= fmt_data;
            end
        end
    end
endmodule

// File: rtl/dram_wr_order_chk.sv
module dram_wr_order_chk #(
    parameter int XW = 8,
    parameter int YW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_strobe,
    input logic          wide16,
    input logic          mirror,
    input logic          step_row,
    input logic          col_load,
    input logic          row_load,
    input logic [7:0]    load_value,
    input logic [XW-1:0] col_end,
    input logic [XW-1:0] ax_q,
    input logic [YW-1:0] ay_q,
    input logic          mem_we,
    input logic [XW-1:0] mem_col,
    input logic [YW-1:0] mem_row
);
    // R2
    we_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |=> mem_we);

    // R2
    we_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_strobe |=> !mem_we);

    // R4
    col_direct_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_strobe && !mirror && !wide16) |=> mem_col == $past(ax_q));

    // R10
    row_out_chk: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |=> mem_row == $past(ay_q));

    // R9
    col_load_chk: assert property (@(posedge clk) disable iff (rst)
        col_load |=> ax_q == XW'($past(load_value)));

    // R6
    col_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_strobe && !step_row && !wide16 && !col_load && !row_load && ax_q < col_end)
        |=> (ax_q == XW'($past(ax_q) + 1'b1) && $stable(ay_q)));
endmodule

bind dram_wr_order dram_wr_order_chk #(.XW(XW), .YW(YW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_strobe  (wr_strobe),
    .wide16     (wide16),
    .mirror     (mirror),
    .step_row   (step_row),
    .col_load   (col_load),
    .row_load   (row_load),
    .load_value (load_value),
    .col_end    (col_end),
    .ax_q       (ax_q),
    .ay_q       (ay_q),
    .mem_we     (mem_we),
    .mem_col    (mem_col),
    .mem_row    (mem_row)
);

// File: tb/dram_wr_order_bench.sv
`timescale 1ns/1ps
module dram_wr_order_bench;
    localparam int LASTC = 191;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        col_load = 1'b0, row_load = 1'b0;
    logic [7:0]  load_value = 8'h00;
    logic        wr_strobe = 1'b0;
    logic [15:0] wr_data = 16'h0000;
    logic        wide16 = 1'b0, mirror = 1'b0, swap_bits = 1'b0, step_row = 1'b0;
    logic [7:0]  col_end = 8'h03, row_end = 8'h01;
    logic        mem_we, mem_pair;
    logic [7:0]  mem_col, mem_row;
    logic [15:0] mem_data;

    int n_chk = 0;
    int n_bad = 0;

    dram_wr_order u_dram_wr_order (
        .clk(clk), .rst(rst), .col_load(col_load), .row_load(row_load),
        .load_value(load_value), .wr_strobe(wr_strobe), .wr_data(wr_data),
        .wide16(wide16), .mirror(mirror), .swap_bits(swap_bits),
        .step_row(step_row), .col_end(col_end), .row_end(row_end),
        .mem_we(mem_we), .mem_pair(mem_pair), .mem_col(mem_col),
        .mem_row(mem_row), .mem_data(mem_data)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] flip(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: integer pointers and expected outputs
    int mx = 0, my = 0;
    logic        e_we = 0, e_pair = 0;
    int          e_col = 0, e_row = 0;
    logic [15:0] e_dat = 0;

    always @(posedge clk) begin
        if (rst) begin
            mx = 0; my = 0; e_we = 0; e_pair = 0; e_col = 0; e_row = 0; e_dat = 0;
        end else begin
            e_we = wr_strobe;
            if (wr_strobe) begin
                logic [7:0] h, l;
                int st;
                h = swap_bits ? flip(wr_data[15:8]) : wr_data[15:8];
                l = swap_bits ? flip(wr_data[7:0])  : wr_data[7:0];
                e_pair = wide16;
                e_row  = my;
                if (!wide16) begin
                    e_col = mirror ? LASTC - mx : mx;
                    e_dat = {8'h00, l};
                end else if (!mirror) begin
                    e_col = mx; e_dat = {h, l};
                end else begin
                    e_col = LASTC - mx - 1; e_dat = {l, h};
                end
                st = wide16 ? 2 : 1;
                if (!step_row) begin
                    if (mx + st > col_end) begin
                        mx = 0;
                        my = (my >= row_end) ? 0 : my + 1;
                    end else mx = mx + st;
                end else begin
                    if (my >= row_end) begin
                        my = 0;
                        mx = (mx + st > col_end) ? 0 : mx + st;
                    end else my = my + 1;
                end
            end
            if (col_load) mx = load_value;
            if (row_load) my = load_value;
        end
    end

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst) begin
            check("R2 mem_we", mem_we, e_we);
            check("R5 mem_pair", mem_pair, e_pair);
            check("R4/R5/R6/R7/R8/R9 mem_col", mem_col, e_col);
            check("R7/R8/R10 mem_row", mem_row, e_row);
            check("R3/R4/R5 mem_data", mem_data, e_dat);
        end
    end

    task automatic do_wr(input logic [15:0] d);
        wr_strobe = 1'b1;
        wr_data   = d;
        @(negedge clk);
        wr_strobe = 1'b0;
    endtask

    task automatic load_ptr(input logic [7:0] x, input logic [7:0] y);
        col_load = 1'b1; load_value = x;
        @(negedge clk);
        col_load = 1'b0; row_load = 1'b1; load_value = y;
        @(negedge clk);
        row_load = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs after reset
        check("R1 mem_we", mem_we, 0);
        check("R1 mem_col", mem_col, 0);
        check("R1 mem_row", mem_row, 0);
        check("R1 mem_data", mem_data, 0);
        rst = 1'b0;
        @(negedge clk);
        // R1: first write lands at column 0 row 0
        do_wr(16'h00AA);
        check("R1 first col", mem_col, 0);
        check("R1 first row", mem_row, 0);

        // R7: column window 0..3, rows 0..1, narrow column-advance
        load_ptr(8'h00, 8'h00);
        for (int i = 0; i < 9; i++) begin
            do_wr(16'(i));
            if (i == 4) begin
                check("R7 wrap col", mem_col, 0);
                check("R7 wrap row", mem_row, 1);
            end
            if (i == 8) begin
                check("R7 row wrap col", mem_col, 0);
                check("R7 row wrap row", mem_row, 0);
            end
        end

        // R8: wide, row-advance
        wide16 = 1'b1; step_row = 1'b1;
        load_ptr(8'h00, 8'h00);
        for (int i = 0; i < 5; i++) begin
            do_wr(16'h1000 + 16'(i));
            if (i == 2) begin
                check("R8 col step", mem_col, 2);
                check("R8 row back", mem_row, 0);
            end
            if (i == 4) check("R8 col wrap", mem_col, 0);
        end

        // R4: mirrored narrow
        wide16 = 1'b0; step_row = 1'b0; mirror = 1'b1;
        col_end = 8'hBF; row_end = 8'h81;
        load_ptr(8'h05, 8'h00);
        do_wr(16'h003C);
        check("R4 mirror col", mem_col, 8'hBA);

        // R5: mirrored pair
        wide16 = 1'b1;
        load_ptr(8'h04, 8'h00);
        do_wr(16'h1234);
        check("R5 mirror col", mem_col, 8'hBA);
        check("R5 mirror data", mem_data, 16'h3412);

        // R3: bit swap, narrow then wide
        mirror = 1'b0; swap_bits = 1'b1; wide16 = 1'b0;
        do_wr(16'h0001);
        check("R3 narrow swap", mem_data, 16'h0080);
        wide16 = 1'b1;
        do_wr(16'h0180);
        check("R3 wide swap", mem_data, 16'h8001);

        // R9: load in the same cycle as a write
        swap_bits = 1'b0; wide16 = 1'b0;
        load_ptr(8'h02, 8'h03);
        col_load = 1'b1; load_value = 8'h07;
        do_wr(16'h0055);
        col_load = 1'b0;
        check("R9 old pointer used", mem_col, 2);
        do_wr(16'h0066);
        check("R9 loaded pointer", mem_col, 7);
        check("R10 row", mem_row, 3);

        // Mixed traffic, compared every cycle against the reference
        col_end = 8'h0F; row_end = 8'h05;
        load_ptr(8'h00, 8'h00);
        for (int i = 0; i < 300; i++) begin
            logic [31:0] r;
            r = $urandom;
            wide16 = r[0]; mirror = r[1]; swap_bits = r[2]; step_row = r[3];
            col_load = (r[7:4] == 4'h0);
            row_load = (r[7:4] == 4'h1);
            load_value = {4'h0, r[11:8]};
            wr_strobe = r[12] | r[13];
            wr_data = r[31:16];
            @(negedge clk);
        end
        wr_strobe = 1'b0; col_load = 1'b0; row_load = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule